// File: doc/BRIEF.md
# Automatic Level Control Gain Sequencer

This block holds the 7-bit input gain code of an automatic level control loop and steps it up or down in response to level events. One code is 0.5 dB, and code 00h is mute. An upstream peak detector supplies three level flags. Each flag says whether the signal is above −6 dB, above −4 dB or above −2 dB. A period tick paces every gain change. Two fade commands ramp the gain on request.

The block has three actions. The limiter cuts gain when the signal is above the trip level. The recovery action raises gain after enough quiet periods have passed. The fade action ramps gain in either direction on command. A single threshold-select bit chooses two levels together: the limiter trip level, and the band that restarts the recovery wait. Each action has its own programmable step size. Cuts stop at mute. Increases stop at a programmable reference ceiling.

Top module: `alc_gain_seq`

## Requirements
- R1: While reset is active and directly after it, `gain` equals `refLevel`. The recovery wait count starts from zero, so a first raise needs `recWaitTicks` quiet ticks after reset.
- R2: With `thrSel`=0 the limiter trips when `lvlAboveMid` is 1. With `thrSel`=1 it trips only when `lvlAboveHi` is 1. A level between −4 dB and −2 dB does not trip when `thrSel`=1.
- R3: On a tick with a trip, the gain drops by `limStepSel`+1 codes (1 to 4).
- R4: A cut that would go below 00h leaves the gain at 00h. This applies to both limiter cuts and fade-out.
- R5: On a recovery, the gain rises by `recStepSel`+1 codes (1 to 4). The result is capped at `refLevel`. A gain already at or above `refLevel` is left unchanged.
- R6: The wait count advances on each tick that has no fade, no trip and no reset-band level. When the count reaches `recWaitTicks`, a recovery happens and the count clears. A recovery needs at least one quiet tick, so values 0 and 1 act alike. The reset band is the −6 dB to −4 dB band (`lvlAboveLo`=1, `lvlAboveMid`=0) with `thrSel`=0. It is the −4 dB to −2 dB band (`lvlAboveMid`=1, `lvlAboveHi`=0) with `thrSel`=1. A reset-band tick clears the count without changing the gain.
- R7: A trip overrides a recovery that is due on the same tick. Any trip clears the wait count.
- R8: The gain changes only on a clock edge where `periodTick` is 1.
- R9: On a tick with `fadeIn` or `fadeOut` active, limiter and recovery do not act, and the wait count clears. `fadeOut` wins over `fadeIn`. A fade-out subtracts `fadeStepSel`+1 codes, stopping at 00h. A fade-in adds `fadeStepSel`+1 codes, capped at `refLevel`, and does not move a gain that is already at or above `refLevel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thrSel | input | 1 | Threshold select: 0 = trip at −4 dB, 1 = trip at −2 dB |
| limStepSel | input | 2 | Limiter cut, minus one, in codes |
| recStepSel | input | 2 | Recovery raise, minus one, in codes |
| fadeStepSel | input | 1 | Fade step, minus one, in codes |
| refLevel | input | 7 | Reference ceiling and reset gain |
| recWaitTicks | input | 4 | Quiet ticks needed before a recovery |
| lvlAboveLo | input | 1 | Signal above −6 dB |
| lvlAboveMid | input | 1 | Signal above −4 dB |
| lvlAboveHi | input | 1 | Signal above −2 dB |
| periodTick | input | 1 | Period strobe that paces gain changes |
| fadeIn | input | 1 | Fade-in command |
| fadeOut | input | 1 | Fade-out command |
| gain | output | 7 | Current gain code (0.5 dB/code, 00h mute) |

## Verification
The hardest cases to reach are a trip that lands on the same tick a recovery falls due, and clamping at mute. The gain must first be driven down close to 00h and the wait count built up to one tick short of its limit. The bench reaches both through an exhaustive sweep of every step, threshold and fade setting. Each configuration opens with a burst of high levels that drives the gain into the floor, then follows with mostly quiet ticks that let recovery climb back to the ceiling. A bench-side arithmetic model predicts every tick. A directed case then lowers the ceiling below the present gain and checks that neither fade-in nor recovery moves it.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int GAIN_W = 7;
  localparam int STEP_W = 3;

  typedef struct packed {
    logic              doCut;
    logic              doRaise;
    logic [STEP_W-1:0] stepCodes;
  } alcStrobes_t;
endpackage

// File: rtl/alc_ctrl.sv
module alc_ctrl
  import alc_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thrSel,
  input  logic [1:0]        limStepSel,
  input  logic [1:0]        recStepSel,
  input  logic              fadeStepSel,
  input  logic [WAIT_W-1:0] recWaitTicks,
  input  logic              lvlAboveLo,
  input  logic              lvlAboveMid,
  input  logic              lvlAboveHi,
  input  logic              periodTick,
  input  logic              fadeIn,
  input  logic              fadeOut,
  output alcStrobes_t       strobes
);
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W:0]   waitNext;
  logic levelTrip, levelZone, fadeAct, waitHit;

  assign levelTrip = thrSel ? lvlAboveHi : lvlAboveMid;
  assign levelZone = thrSel ? (lvlAboveMid & ~lvlAboveHi) : (lvlAboveLo & ~lvlAboveMid);
  assign fadeAct   = fadeIn | fadeOut;
  assign waitNext  = {1'b0, waitCnt} + 1'b1;
  assign waitHit   = waitNext >= {1'b0, recWaitTicks};

  always_comb begin
    strobes = '0;
    if (periodTick) begin
      if (fadeOut) begin
        strobes.doCut     = 1'b1;
        strobes.stepCodes = STEP_W'(fadeStepSel) + 1'b1;
      end else if (fadeIn) begin
        strobes.doRaise   = 1'b1;
        strobes.stepCodes = STEP_W'(fadeStepSel) + 1'b1;
      end else if (levelTrip) begin
        strobes.doCut     = 1'b1;
        strobes.stepCodes = STEP_W'(limStepSel) + 1'b1;
      end else if (!levelZone && waitHit) begin
        strobes.doRaise   = 1'b1;
        strobes.stepCodes = STEP_W'(recStepSel) + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waitCnt <= '0;
    end else if (periodTick) begin
      if (fadeAct || levelTrip || levelZone || waitHit) waitCnt <= '0;
      else waitCnt <= waitNext[WAIT_W-1:0];
    end
  end

  assert_single_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.doCut, strobes.doRaise}));
  assert_tick_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !periodTick |-> !(strobes.doCut || strobes.doRaise));
  assert_trip_clears_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (periodTick && levelTrip) |=> (waitCnt == '0));
  assert_fade_in_blocks_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (periodTick && fadeIn && !fadeOut) |-> !strobes.doCut);
endmodule

// File: rtl/alc_datapath.sv
module alc_datapath
  import alc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAIN_W-1:0] refLevel,
  input  alcStrobes_t       strobes,
  output logic [GAIN_W-1:0] gain
);
  logic [GAIN_W:0]   raiseSum;
  logic [GAIN_W-1:0] cutVal, raiseVal, stepExt;

  assign stepExt  = GAIN_W'(strobes.stepCodes);
  assign cutVal   = (gain > stepExt) ? (gain - stepExt) : '0;
  assign raiseSum = {1'b0, gain} + {1'b0, stepExt};
  always_comb begin
    if (gain >= refLevel)                raiseVal = gain;
    else if (raiseSum > {1'b0, refLevel}) raiseVal = refLevel;
    else                                  raiseVal = raiseSum[GAIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               gain <= refLevel;
    else if (strobes.doCut)   gain <= cutVal;
    else if (strobes.doRaise) gain <= raiseVal;
  end

  assert_cut_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.doCut |=> (gain <= $past(gain)));
  assert_raise_capped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.doRaise && gain < refLevel) |=> (gain <= $past(refLevel) && gain > $past(gain)));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.doCut || strobes.doRaise) |=> $stable(gain));
endmodule

// File: rtl/alc_gain_seq.sv
module alc_gain_seq
  import alc_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thrSel,
  input  logic [1:0]        limStepSel,
  input  logic [1:0]        recStepSel,
  input  logic              fadeStepSel,
  input  logic [GAIN_W-1:0] refLevel,
  input  logic [WAIT_W-1:0] recWaitTicks,
  input  logic              lvlAboveLo,
  input  logic              lvlAboveMid,
  input  logic              lvlAboveHi,
  input  logic              periodTick,
  input  logic              fadeIn,
  input  logic              fadeOut,
  output logic [GAIN_W-1:0] gain
);
  alcStrobes_t strobes;

  alc_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .thrSel(thrSel), .limStepSel(limStepSel),
    .recStepSel(recStepSel), .fadeStepSel(fadeStepSel), .recWaitTicks(recWaitTicks),
    .lvlAboveLo(lvlAboveLo), .lvlAboveMid(lvlAboveMid), .lvlAboveHi(lvlAboveHi),
    .periodTick(periodTick), .fadeIn(fadeIn), .fadeOut(fadeOut), .strobes(strobes)
  );

  alc_datapath u_datapath (
    .clk(clk), .rst_n(rst_n), .refLevel(refLevel), .strobes(strobes), .gain(gain)
  );
endmodule

// File: tb/alc_gain_seq_bench.sv
module alc_gain_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thrSel = 1'b0;
  logic [1:0] limStepSel = '0, recStepSel = '0;
  logic fadeStepSel = 1'b0;
  logic [6:0] refLevel = 7'd20;
  logic [3:0] recWaitTicks = 4'd1;
  logic lvlAboveLo = 0, lvlAboveMid = 0, lvlAboveHi = 0;
  logic periodTick = 0, fadeIn = 0, fadeOut = 0;
  logic [6:0] gain;

  int tests = 0, fails = 0;
  int mGain = 0, mCnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alc_gain_seq u_alc_gain_seq (
    .clk(clk), .rst_n(rst_n), .thrSel(thrSel), .limStepSel(limStepSel),
    .recStepSel(recStepSel), .fadeStepSel(fadeStepSel), .refLevel(refLevel),
    .recWaitTicks(recWaitTicks), .lvlAboveLo(lvlAboveLo), .lvlAboveMid(lvlAboveMid),
    .lvlAboveHi(lvlAboveHi), .periodTick(periodTick), .fadeIn(fadeIn),
    .fadeOut(fadeOut), .gain(gain)
  );

  task automatic check(string req, int exp);
    tests++;
    if (int'(gain) != exp) begin
      fails++;
      $display("FAIL %s: gain=%0d expected=%0d", req, gain, exp);
    end
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 0; periodTick = 0; fadeIn = 0; fadeOut = 0;
    lvlAboveLo = 0; lvlAboveMid = 0; lvlAboveHi = 0;
    @(negedge clk);
    check("R1", int'(refLevel));
    rst_n = 1;
    @(negedge clk);
    check("R1", int'(refLevel));
    mGain = int'(refLevel); mCnt = 0;
  endtask

  // lvl: 0 below -6 dB, 1 in -6..-4, 2 in -4..-2, 3 above -2 dB
  task automatic tickOnce(int lvl, bit fi, bit fo);
    int fs, ls, rs, rf, wt;
    bit trip, zone;
    string tag;
    lvlAboveLo = (lvl >= 1); lvlAboveMid = (lvl >= 2); lvlAboveHi = (lvl >= 3);
    fadeIn = fi; fadeOut = fo; periodTick = 0;
    @(negedge clk);
    check("R8", mGain);
    fs = int'(fadeStepSel) + 1; ls = int'(limStepSel) + 1; rs = int'(recStepSel) + 1;
    rf = int'(refLevel); wt = (recWaitTicks == 0) ? 1 : int'(recWaitTicks);
    trip = thrSel ? (lvl == 3) : (lvl >= 2);
    zone = thrSel ? (lvl == 2) : (lvl == 1);
    if (fo) begin
      tag = "R9"; mGain = (mGain > fs) ? mGain - fs : 0; mCnt = 0;
    end else if (fi) begin
      tag = "R9"; if (mGain < rf) mGain = (mGain + fs > rf) ? rf : mGain + fs; mCnt = 0;
    end else if (trip) begin
      tag = (mCnt + 1 >= wt) ? "R7" : (mGain < ls ? "R4" : "R3");
      mGain = (mGain > ls) ? mGain - ls : 0; mCnt = 0;
    end else if (zone) begin
      tag = (thrSel && lvl == 2) ? "R2" : "R6"; mCnt = 0;
    end else if (mCnt + 1 >= wt) begin
      tag = "R5"; if (mGain < rf) mGain = (mGain + rs > rf) ? rf : mGain + rs; mCnt = 0;
    end else begin
      tag = "R6"; mCnt++;
    end
    periodTick = 1;
    @(negedge clk);
    periodTick = 0; fadeIn = 0; fadeOut = 0;
    check(tag, mGain);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    for (int cfg = 0; cfg < 64; cfg++) begin
      thrSel = cfg[0]; fadeStepSel = cfg[1];
      limStepSel = cfg[3:2]; recStepSel = cfg[5:4];
      refLevel = 7'(5 + cfg);
      recWaitTicks = 4'(1 + (cfg % 3));
      doReset();
      for (int t = 0; t < 60; t++) begin
        int lvl;
        bit fi, fo;
        stepLfsr();
        if (t < 20) lvl = int'(lfsr[1:0]) | 2;
        else if (t < 25) lvl = int'(lfsr[1:0]);
        else lvl = (lfsr[3:0] == 0) ? int'(lfsr[5:4]) : 0;
        fi = (lfsr[8:6] == 0);
        fo = (lfsr[11:9] == 0);
        tickOnce(lvl, fi, fo);
      end
    end
    // R2 directed: -4..-2 dB does not trip with thrSel=1
    thrSel = 1; limStepSel = 2'd3; recWaitTicks = 4'd2; refLevel = 7'd30;
    doReset();
    tickOnce(2, 0, 0);
    // R4 directed: limiter clamp at mute from a small gain
    thrSel = 0; refLevel = 7'd3;
    doReset();
    tickOnce(3, 0, 0);
    tickOnce(3, 0, 0);
    // R5/R9 directed: ceiling lowered below the current gain
    refLevel = 7'd40;
    doReset();
    refLevel = 7'd20;
    tickOnce(0, 1, 0);
    tickOnce(0, 0, 0);
    tickOnce(0, 0, 0);
    tickOnce(0, 0, 0);
    // R9: fadeOut wins when both fade commands are active
    tickOnce(0, 1, 1);
    finish();
  end
endmodule